// File: doc/BRIEF.md
# Circular Pass-Window Phase Selector

This block chooses a sampling phase from the outcome of a full sweep over the phases of a delay line. The caller supplies a pass mask, with bit n set when phase n sampled correctly, and pulses a start strobe. The block groups the passing phases into windows of consecutive phase numbers. It treats the phase ring as circular, so a window that runs up to the top phase continues into a window that begins at phase 0. It keeps the longest window and returns the phase that lies about three quarters of the way into it, so the choice leans towards the later edge of the window.

The search is a combinational network that settles within one cycle. The result is registered on the edge that samples the strobe and is held until the next strobe. A mask with no passing phase raises the error flag in place of a valid result.

Top module: `pws_phase_pick`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` is 0, `err_o` is 0 and `phase_o` is 0.
- R2: On a clock edge where `start_i` is 1, the block samples `mask_i` and updates its three outputs on that same edge. While `start_i` stays 0, the outputs keep their values, whatever `mask_i` does.
- R3: Bit n of `mask_i` stands for phase n. A window is a maximal run of set bits at consecutive bit positions. A clear bit ends a window, and the next set bit starts a new one.
- R4: When bit 0 and bit 15 (the top phase) are both set and at least one bit is clear, the window that holds phase 15 and the window that holds phase 0 form one window. It is ordered from its lowest phase up to 15 and then from 0 upward, so the chosen phase is (start of the upper part + offset) mod 16.
- R5: An all-ones mask is a single window of 16 phases that starts at phase 0, so `phase_o` is 11.
- R6: The longest window wins. On a tie, the window whose first phase is lowest wins. A merged window ranks by the first phase of its upper part.
- R7: If the winning window has length L, the offset into it is floor(3L/4) minus one, or 0 when floor(3L/4) is 0. `phase_o` is the phase at that offset.
- R8: An all-zero mask gives `err_o` = 1, `valid_o` = 0 and `phase_o` = 0.
- R9: Whenever `valid_o` is 1, the bit of the most recently sampled mask at position `phase_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Sample the mask and update the result on this edge |
| mask_i | input | 16 | Pass mask from the sweep, bit n for phase n |
| phase_o | output | 4 | Selected sampling phase |
| valid_o | output | 1 | Result holds a selected phase |
| err_o | output | 1 | The last sampled mask had no passing phase |

## Verification
The bench walks every one of the 65536 masks and compares each result with a model that measures the windows as arcs on a circle. That model is arithmetically different from the linear-scan-then-merge structure of the design. A design that dropped the wrap merge would return a point inside the lower fragment, or inside a shorter window, for masks with both bit 0 and bit 15 set. A design that merged the all-ones mask would double the length and land on the wrong phase. Directed cases target ties, including a tie between a merged window and a plain one, where letting the later window win, or ranking the merged window by phase 0, moves the answer. They also cover the minus-one rule on short windows, the empty mask, and holding the result while the mask changes with no strobe.

// File: rtl/pws_pkg.sv
// Shared helpers for the circular pass-window phase selector.
// Assumes window lengths fit in 32 bits (always true for small phase counts).
package pws_pkg;

    // Offset into a window of length len: floor(3*len/4), less one when nonzero.
    function automatic int unsigned tq_offset(input int unsigned len);
        int unsigned o;
        o = (len * 3) / 4;
        if (o != 0) o = o - 1;
        return o;
    endfunction

endpackage

// File: rtl/pws_run_len.sv
// Linear run finder: flags each phase that opens a window (no wrap considered)
// and measures the run of passing phases from that phase upward to the top.
// Assumes NPH >= 2. Lengths are only meaningful where is_start is set.
module pws_run_len #(
    parameter int NPH   = 16,
    parameter int LEN_W = 5
) (
    input  logic [NPH-1:0]            mask,
    output logic [NPH-1:0]            is_start,
    output logic [NPH-1:0][LEN_W-1:0] run_len
);

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        logic [LEN_W-1:0] cnt;

        if (p == 0) begin : g_first
            assign is_start[p] = mask[0];
        end else begin : g_rest
            assign is_start[p] = mask[p] & ~mask[p-1];
        end

        // Count consecutive passing phases from p upward until the first fail.
        always_comb begin
            logic run;
            run = 1'b1;
            cnt = '0;
            for (int q = p; q < NPH; q++) begin
                run = run & mask[q];
                cnt = cnt + LEN_W'(run);
            end
        end

        assign run_len[p] = cnt;
    end

endmodule

// File: rtl/pws_wrap_merge.sv
// Wrap merge: when the ring is broken somewhere and both the bottom and top
// phases pass, folds the window at phase 0 onto the window reaching the top
// phase, which keeps its own start position. Assumes inputs from pws_run_len.
module pws_wrap_merge #(
    parameter int NPH     = 16,
    parameter int PHASE_W = 4,
    parameter int LEN_W   = 5
) (
    input  logic [NPH-1:0]            mask,
    input  logic [NPH-1:0]            is_start,
    input  logic [NPH-1:0][LEN_W-1:0] run_len,
    output logic [NPH-1:0][LEN_W-1:0] eff_len
);

    logic               wrap;
    logic [PHASE_W-1:0] last_start;

    // Locate the start of the highest window and fold the bottom window into it.
    always_comb begin
        wrap       = mask[0] & mask[NPH-1] & ~(&mask);
        last_start = '0;
        for (int p = 0; p < NPH; p++) begin
            if (is_start[p]) last_start = PHASE_W'(p);
        end
        eff_len = run_len;
        if (wrap) begin
            eff_len[last_start] = run_len[last_start] + run_len[0];
            eff_len[0]          = '0;
        end
    end

endmodule

// File: rtl/pws_pick.sv
// Window picker: keeps the longest window (lowest start on ties) and returns
// the phase three quarters of the way in, modulo the ring size.
// Assumes NPH == 2**PHASE_W so the phase adder wraps naturally.
module pws_pick #(
    parameter int NPH     = 16,
    parameter int PHASE_W = 4,
    parameter int LEN_W   = 5
) (
    input  logic [NPH-1:0]            is_start,
    input  logic [NPH-1:0][LEN_W-1:0] eff_len,
    output logic [PHASE_W-1:0]        phase,
    output logic                      empty
);

    logic [LEN_W-1:0]   best_len;
    logic [PHASE_W-1:0] best_start;
    logic [PHASE_W-1:0] off;

    // Strict-greater scan in ascending start order keeps the first of equals.
    always_comb begin
        best_len   = '0;
        best_start = '0;
        for (int p = 0; p < NPH; p++) begin
            if (is_start[p] && (eff_len[p] > best_len)) begin
                best_len   = eff_len[p];
                best_start = PHASE_W'(p);
            end
        end
    end

    // Biased offset and wrapped phase of the chosen window.
    always_comb begin
        off   = PHASE_W'(pws_pkg::tq_offset(32'(best_len)));
        phase = best_start + off;
        empty = (best_len == '0);
    end

endmodule

// File: rtl/pws_phase_pick.sv
// Circular pass-window phase selector, top level. Samples the pass mask on a
// start strobe and registers the selected phase with valid and error flags,
// holding them until the next strobe. Synchronous active-low reset.
module pws_phase_pick #(
    parameter int PHASE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [(1<<PHASE_W)-1:0]    mask_i,
    output logic [PHASE_W-1:0]         phase_o,
    output logic                       valid_o,
    output logic                       err_o
);

    localparam int NPH   = 1 << PHASE_W;
    localparam int LEN_W = PHASE_W + 1;

    logic [NPH-1:0]            is_start;
    logic [NPH-1:0][LEN_W-1:0] run_len;
    logic [NPH-1:0][LEN_W-1:0] eff_len;
    logic [PHASE_W-1:0]        phase_c;
    logic                      empty_c;

    pws_run_len #(.NPH(NPH), .LEN_W(LEN_W)) u_runs (
        .mask     (mask_i),
        .is_start (is_start),
        .run_len  (run_len)
    );

    pws_wrap_merge #(.NPH(NPH), .PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_merge (
        .mask     (mask_i),
        .is_start (is_start),
        .run_len  (run_len),
        .eff_len  (eff_len)
    );

    pws_pick #(.NPH(NPH), .PHASE_W(PHASE_W), .LEN_W(LEN_W)) u_pick (
        .is_start (is_start),
        .eff_len  (eff_len),
        .phase    (phase_c),
        .empty    (empty_c)
    );

    // Result register: loads on the strobe, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else if (start_i) begin
            phase_o <= empty_c ? '0 : phase_c;
            valid_o <= ~empty_c;
            err_o   <= empty_c;
        end
    end

endmodule

// File: rtl/pws_phase_pick_chk.sv
// Property checker for pws_phase_pick, bound to every instance of the top.
// Keeps its own copy of the last sampled mask to relate the output to it.
module pws_phase_pick_chk #(
    parameter int PHASE_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [(1<<PHASE_W)-1:0] mask_i,
    input logic [PHASE_W-1:0]      phase_o,
    input logic                    valid_o,
    input logic                    err_o
);

    localparam int NPH = 1 << PHASE_W;

    logic [NPH-1:0] cap_mask;

    // Shadow of the mask sampled on the latest strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_mask <= '0;
        else if (start_i) cap_mask <= mask_i;
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(phase_o) && $stable(valid_o) && $stable(err_o)));

    // R8
    empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mask_i == '0) |=> (err_o && !valid_o && phase_o == '0));

    // R3
    nonempty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mask_i != '0) |=> (valid_o && !err_o));

    // R5
    full_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (&mask_i)) |=> (phase_o == PHASE_W'(NPH * 3 / 4 - 1)));

    // R9
    pass_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cap_mask[phase_o]);

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

endmodule

bind pws_phase_pick pws_phase_pick_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/pws_phase_pick_bench.sv
`timescale 1ns/1ps
module pws_phase_pick_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [3:0]  phase_o;
    logic        valid_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pws_phase_pick #(.PHASE_W(4)) u_pws_phase_pick (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .phase_o(phase_o), .valid_o(valid_o), .err_o(err_o)
    );

    // Reference: windows as circular arcs; returns {err, valid, phase}.
    function automatic logic [5:0] ref_pick(input logic [15:0] m);
        int best_l, best_s, l, off;
        if (m == 16'h0000) return {1'b1, 1'b0, 4'd0};
        if (m == 16'hFFFF) return {1'b0, 1'b1, 4'd11};
        best_l = 0;
        best_s = 0;
        for (int s = 0; s < 16; s++) begin
            if (m[s] && !m[(s + 15) % 16]) begin
                l = 0;
                while (m[(s + l) % 16]) l++;
                if (l > best_l) begin
                    best_l = l;
                    best_s = s;
                end
            end
        end
        off = (best_l * 3) / 4;
        if (off > 0) off--;
        return {1'b0, 1'b1, 4'((best_s + off) % 16)};
    endfunction

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got={err,valid,phase}=%h exp=%h", tag, got, exp);
        end
    endtask

    // One strobe with mask m, sampled at the following falling edge.
    task automatic apply(input logic [15:0] m);
        mask_i  = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic directed(input string tag, input logic [15:0] m, input logic [5:0] exp);
        apply(m);
        check(tag, {err_o, valid_o, phase_o}, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [5:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset", {err_o, valid_o, phase_o}, 6'b00_0000);

        // R3 plain windows
        directed("R3 single run 2..5", 16'h003C, {2'b01, 4'd4});
        directed("R3 two runs", 16'h0602, {2'b01, 4'd9});
        // R7 offset rule
        directed("R7 len1", 16'h0020, {2'b01, 4'd5});
        directed("R7 len8", 16'h0FF0, {2'b01, 4'd9});
        // R6 ties
        directed("R6 tie plain", 16'h070E, {2'b01, 4'd2});
        directed("R6 tie vs merged", 16'hC1E3, {2'b01, 4'd7});
        // R4 wrap merge
        directed("R4 wrap len6", 16'hE007, {2'b01, 4'd0});
        directed("R4 wrap len2", 16'h8001, {2'b01, 4'd15});
        // R5 full ring
        directed("R5 all ones", 16'hFFFF, {2'b01, 4'd11});
        // R8 empty
        directed("R8 empty", 16'h0000, {2'b10, 4'd0});

        // R2 hold while mask changes without a strobe
        apply(16'h00F0);
        snap = {err_o, valid_o, phase_o};
        check("R2 load", snap, ref_pick(16'h00F0));
        mask_i = 16'h0003;
        repeat (3) @(negedge clk);
        check("R2 hold", {err_o, valid_o, phase_o}, snap);
        mask_i = 16'h0000;
        @(negedge clk);
        check("R2 hold empty mask", {err_o, valid_o, phase_o}, snap);

        // Exhaustive sweep with a strobe every cycle
        start_i = 1'b1;
        for (int m = 0; m < 65536; m++) begin
            string tag;
            mask_i = 16'(m);
            @(negedge clk);
            if (m == 0)                               tag = "R8 sweep";
            else if (m == 65535)                      tag = "R5 sweep";
            else if (mask_i[0] && mask_i[15])         tag = "R4 sweep";
            else                                      tag = "R6 sweep";
            check(tag, {err_o, valid_o, phase_o}, ref_pick(16'(m)));
            if (valid_o) begin
                checks++;
                if (!mask_i[phase_o]) begin
                    failures++;
                    $display("FAIL R9 mask=%h phase got=%0d not passing (exp a set bit)",
                             mask_i, phase_o);
                end
            end
        end
        start_i = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule